// File: doc/BRIEF.md
# Reset Sequencer with Strap Capture

This block produces the on-chip system reset from an external active-low reset pin and the lock outputs of a set of PLLs. Each PLL's output clock stays gated off until that PLL reports lock. The system reset is released on one clean edge of the system clock, but only once the external reset has been removed and every PLL marked as active is locked. A lock-override strap takes lock out of both the clock gating and the reset release.

On the edge where the system reset is released, the block samples the bootstrap pins into a holding register. These are a 16-bit general-purpose strap bus plus the debug-enable, break and lock-override straps. Any peripheral that is reset again later, for example after being clock-gated, reads its boot configuration from this register and not from the live pins. The block decodes the held values into several outputs: clock enables for the debug and Ethernet domains, two debug-link enables, a two-bit distributed-interrupt mode, the watchdog enable, the start permission for the first processor, and the boot-memory settings. The held values are also exposed as a read-only 32-bit status word.

Top module: `rstseq_top`

## Requirements
- R1: `sys_rst_n` is low while `ext_rst_n` is low. It rises on the third rising clock edge at which both of these have been true through the two synchronizer stages: `ext_rst_n` high, and every PLL whose bit is set in `ACTIVE_MASK` locked. It then stays high until `ext_rst_n` is asserted again.
- R2: `pll_clk_en[i]` equals the lock input of PLL i delayed by two system-clock edges. It is forced high while `strap_lock_ignore` is high.
- R3: While `strap_lock_ignore` is high, the lock inputs have no effect on reset release. `sys_rst_n` then rises on the third edge after `ext_rst_n` deasserts, even with no PLL locked.
- R4: The straps are captured on the edge where `sys_rst_n` rises. Later pin changes have no effect on any decoded output or on `boot_status` until the next assertion of `ext_rst_n`. `boot_status` layout: [15:0] general-purpose straps, [16] debug enable, [17] break, [18] lock override, [30:19] zero, [31] set once the straps are held. The whole word is zero during external reset.
- R5: If the held debug-enable strap is low, `dbg_clk_en`, `eth_clk_en` and both bits of `dbg_link_en` are low. If it is high, `dbg_clk_en` and `eth_clk_en` are high.
- R6: `dbg_link_en[0]` is high only when debug is enabled and held strap bits [3:0] are not 4'b1111. `dbg_link_en[1]` is high only when debug is enabled and held bits [7:4] are not 4'b1111.
- R7: `dint_mode` equals held strap bits [7:6]. The codes are: 2'b00 is 32 interrupts with acknowledge; 2'b01 is 64 interrupts without acknowledge; 2'b10 is disabled, with all codes treated as time codes; 2'b11 is disabled, with a control code treated as a time code only when its control flags are zero.
- R8: `wdog_en` is high when the held debug-enable strap is low and the held break strap is high. `cpu0_start` is high when `sys_rst_n` is high and the held break strap is low.
- R9: `bootmem_edac_en` equals held strap bit 14. `bootmem_full_if` is high when held strap bit 15 is low.
- R10: A PLL whose bit in `ACTIVE_MASK` is clear does not hold back reset release. Its clock enable still follows its own lock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| ext_rst_n | input | 1 | External reset, active low, asynchronous assert |
| pll_lock | input | NUM_PLL | Lock indication per PLL |
| strap_lock_ignore | input | 1 | Lock-override strap |
| strap_dbg_en | input | 1 | Debug-enable strap |
| strap_break | input | 1 | Break strap |
| strap_gpio | input | GPIO_W | General-purpose strap bus |
| sys_rst_n | output | 1 | System reset, active low |
| pll_clk_en | output | NUM_PLL | Clock gate enable per PLL |
| dbg_clk_en | output | 1 | Debug domain clock enable |
| eth_clk_en | output | 1 | Ethernet controller clock enable |
| dbg_link_en | output | 2 | Ethernet debug link enables |
| dint_mode | output | 2 | Distributed-interrupt mode |
| wdog_en | output | 1 | Watchdog timer enable |
| cpu0_start | output | 1 | First processor may execute |
| bootmem_edac_en | output | 1 | Boot-memory EDAC enable reset value |
| bootmem_full_if | output | 1 | Full boot-memory interface selected |
| boot_status | output | 32 | Read-only view of the held straps |

## Verification
Two events can fall on the same clock edge: a strap pin changing, and the reset release that captures the straps. The bench provokes this by stepping the strap bus on every cycle across the release window, and by raising the last lock in the same cycle that the external reset is removed. It then judges the result with a behavioural model that samples the pins at the modelled release edge. The model also expects any change one cycle later to be ignored.

// File: rtl/rstseq_pkg.sv
package rstseq_pkg;
   localparam int STATUS_W = 32;
   localparam int ST_DBG_BIT = 16;
   localparam int ST_BRK_BIT = 17;
   localparam int ST_IGN_BIT = 18;
   localparam int ST_VALID_BIT = 31;

   typedef struct packed {
      logic [15:0] gp;
      logic        dbg_en;
      logic        brk;
      logic        lock_ign;
   } strap_t;

   function automatic logic [STATUS_W-1:0] pack_status(strap_t s, logic valid);
      logic [STATUS_W-1:0] w;
      w = '0;
      w[15:0] = s.gp;
      w[ST_DBG_BIT] = s.dbg_en;
      w[ST_BRK_BIT] = s.brk;
      w[ST_IGN_BIT] = s.lock_ign;
      w[ST_VALID_BIT] = valid;
      return w;
   endfunction
endpackage

// File: rtl/rsq_sync.sv
module rsq_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic arst_n,
   input  logic d,
   output logic q
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("rsq_sync needs at least two stages");
      end
   endgenerate

   logic [STAGES-1:0] chain;

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) chain <= {STAGES{RST_VAL}};
      else         chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/rsq_release.sv
module rsq_release #(
   parameter int                NUM_PLL     = 3,
   parameter logic [NUM_PLL-1:0] ACTIVE_MASK = '1,
   parameter int                SYNC_STAGES = 2
) (
   input  logic               clk,
   input  logic               ext_rst_n,
   input  logic [NUM_PLL-1:0] pll_lock,
   input  logic               lock_ignore,
   output logic [NUM_PLL-1:0] pll_clk_en,
   output logic               sys_rst_n,
   output logic               capture
);
   logic               ext_ok;
   logic [NUM_PLL-1:0] lock_s;
   logic [NUM_PLL-1:0] lock_need;
   logic               release_ok;
   logic               rel_q;

   rsq_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_ext_sync (
      .clk(clk), .arst_n(ext_rst_n), .d(1'b1), .q(ext_ok));

   genvar i;
   generate
      for (i = 0; i < NUM_PLL; i++) begin : g_pll
         rsq_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_lock_sync (
            .clk(clk), .arst_n(ext_rst_n), .d(pll_lock[i]), .q(lock_s[i]));

         assign pll_clk_en[i] = lock_s[i] | lock_ignore;

         if (ACTIVE_MASK[i]) begin : g_active
            assign lock_need[i] = lock_s[i];
         end else begin : g_passive
            assign lock_need[i] = 1'b1;
         end

         // R2: a gate opens without override only after a lock two edges back
         assert_gate_follows_lock_R2: assert property (@(posedge clk) disable iff (!ext_rst_n)
            (!lock_ignore && pll_clk_en[i]) |-> $past(pll_lock[i], SYNC_STAGES));
      end
   endgenerate

   assign release_ok = ext_ok & (lock_ignore | (&lock_need));
   assign capture    = release_ok & ~rel_q;

   always_ff @(posedge clk or negedge ext_rst_n) begin
      if (!ext_rst_n)      rel_q <= 1'b0;
      else if (release_ok) rel_q <= 1'b1;
   end

   assign sys_rst_n = rel_q;

   // R1 / R3 / R10: release only after the synchronized conditions held
   assert_release_gated_R1: assert property (@(posedge clk) disable iff (!ext_rst_n)
      $rose(sys_rst_n) |-> $past(ext_ok) && ($past(lock_ignore) || $past(&lock_need)));
   assert_release_sticky_R1: assert property (@(posedge clk) disable iff (!ext_rst_n)
      sys_rst_n |=> sys_rst_n);
endmodule

// File: rtl/rsq_strap_hold.sv
module rsq_strap_hold
   import rstseq_pkg::*;
(
   input  logic   clk,
   input  logic   ext_rst_n,
   input  logic   capture,
   input  strap_t pins,
   output strap_t held,
   output logic   valid
);
   always_ff @(posedge clk or negedge ext_rst_n) begin
      if (!ext_rst_n) begin
         held  <= '0;
         valid <= 1'b0;
      end else if (capture) begin
         held  <= pins;
         valid <= 1'b1;
      end
   end

   // R4: the held straps never move outside a capture
   assert_hold_stable_R4: assert property (@(posedge clk) disable iff (!ext_rst_n)
      !capture |=> $stable(held));
   assert_single_capture_R4: assert property (@(posedge clk) disable iff (!ext_rst_n)
      valid |-> !capture);
endmodule

// File: rtl/rsq_strap_decode.sv
module rsq_strap_decode #(
   parameter int NIB_W = 4
) (
   input  logic             dbg_en,
   input  logic             brk,
   input  logic             released,
   input  logic [2*NIB_W-1:0] link_nibs,
   input  logic [1:0]       boot_bits,
   output logic             dbg_clk_en,
   output logic             eth_clk_en,
   output logic [1:0]       dbg_link_en,
   output logic [1:0]       dint_mode,
   output logic             wdog_en,
   output logic             cpu0_start,
   output logic             bootmem_edac_en,
   output logic             bootmem_full_if
);
   localparam logic [NIB_W-1:0] OFF_CODE = '1;

   genvar k;
   generate
      for (k = 0; k < 2; k++) begin : g_link
         assign dbg_link_en[k] = dbg_en & (link_nibs[k*NIB_W +: NIB_W] != OFF_CODE);
      end
   endgenerate

   assign dbg_clk_en      = dbg_en;
   assign eth_clk_en      = dbg_en;
   assign dint_mode       = link_nibs[2*NIB_W-1 -: 2];
   assign wdog_en         = ~dbg_en & brk;
   assign cpu0_start      = released & ~brk;
   assign bootmem_edac_en = boot_bits[0];
   assign bootmem_full_if = ~boot_bits[1];
endmodule

// File: rtl/rstseq_top.sv
module rstseq_top
   import rstseq_pkg::*;
#(
   parameter int                NUM_PLL     = 3,
   parameter logic [NUM_PLL-1:0] ACTIVE_MASK = 3'b011,
   parameter int                SYNC_STAGES = 2,
   parameter int                GPIO_W      = 16
) (
   input  logic               clk,
   input  logic               ext_rst_n,
   input  logic [NUM_PLL-1:0] pll_lock,
   input  logic               strap_lock_ignore,
   input  logic               strap_dbg_en,
   input  logic               strap_break,
   input  logic [GPIO_W-1:0]  strap_gpio,
   output logic               sys_rst_n,
   output logic [NUM_PLL-1:0] pll_clk_en,
   output logic               dbg_clk_en,
   output logic               eth_clk_en,
   output logic [1:0]         dbg_link_en,
   output logic [1:0]         dint_mode,
   output logic               wdog_en,
   output logic               cpu0_start,
   output logic               bootmem_edac_en,
   output logic               bootmem_full_if,
   output logic [31:0]        boot_status
);
   localparam int NIB_W    = 4;
   localparam int EDAC_BIT = 14;
   localparam int BIF_BIT  = 15;

   generate
      if (GPIO_W != 16) begin : g_bad_gpio
         $error("strap bus must be 16 bits wide");
      end
      if (NUM_PLL < 1 || NUM_PLL > 8) begin : g_bad_pll
         $error("NUM_PLL out of range");
      end
   endgenerate

   logic   capture;
   logic   valid;
   strap_t pins;
   strap_t held;

   assign pins.gp       = strap_gpio;
   assign pins.dbg_en   = strap_dbg_en;
   assign pins.brk      = strap_break;
   assign pins.lock_ign = strap_lock_ignore;

   rsq_release #(.NUM_PLL(NUM_PLL), .ACTIVE_MASK(ACTIVE_MASK), .SYNC_STAGES(SYNC_STAGES)) u_release (
      .clk(clk), .ext_rst_n(ext_rst_n), .pll_lock(pll_lock), .lock_ignore(strap_lock_ignore),
      .pll_clk_en(pll_clk_en), .sys_rst_n(sys_rst_n), .capture(capture));

   rsq_strap_hold u_hold (
      .clk(clk), .ext_rst_n(ext_rst_n), .capture(capture), .pins(pins),
      .held(held), .valid(valid));

   rsq_strap_decode #(.NIB_W(NIB_W)) u_decode (
      .dbg_en(held.dbg_en), .brk(held.brk), .released(sys_rst_n),
      .link_nibs(held.gp[2*NIB_W-1:0]), .boot_bits({held.gp[BIF_BIT], held.gp[EDAC_BIT]}),
      .dbg_clk_en(dbg_clk_en), .eth_clk_en(eth_clk_en), .dbg_link_en(dbg_link_en),
      .dint_mode(dint_mode), .wdog_en(wdog_en), .cpu0_start(cpu0_start),
      .bootmem_edac_en(bootmem_edac_en), .bootmem_full_if(bootmem_full_if));

   assign boot_status = pack_status(held, valid);

   // R5 / R6: link enables at release reflect the pins seen at that edge
   assert_link0_at_release_R6: assert property (@(posedge clk) disable iff (!ext_rst_n)
      $rose(sys_rst_n) |-> dbg_link_en[0] == ($past(strap_dbg_en) && ($past(strap_gpio[3:0]) != 4'hF)));
   assert_link1_at_release_R6: assert property (@(posedge clk) disable iff (!ext_rst_n)
      $rose(sys_rst_n) |-> dbg_link_en[1] == ($past(strap_dbg_en) && ($past(strap_gpio[7:4]) != 4'hF)));
   assert_dbg_domain_R5: assert property (@(posedge clk) disable iff (!ext_rst_n)
      $rose(sys_rst_n) |-> (eth_clk_en == $past(strap_dbg_en)));
   // R8: watchdog enable taken from the pins at the release edge
   assert_wdog_at_release_R8: assert property (@(posedge clk) disable iff (!ext_rst_n)
      $rose(sys_rst_n) |-> wdog_en == ($past(!strap_dbg_en && strap_break)));
   // R4: status word marked valid together with the release
   assert_status_valid_R4: assert property (@(posedge clk) disable iff (!ext_rst_n)
      boot_status[31] == sys_rst_n);
endmodule

// File: tb/rstseq_top_tb.sv
module rstseq_top_tb;
   localparam int NP = 3;
   localparam logic [NP-1:0] ACT = 3'b011;

   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   logic          ext_rst_n = 1'b0;
   logic [NP-1:0] pll_lock = '0;
   logic          ign = 1'b0, dbg = 1'b0, brk = 1'b0;
   logic [15:0]   gp = '0;

   logic          sys_rst_n;
   logic [NP-1:0] pll_clk_en;
   logic          dbg_clk_en, eth_clk_en, wdog_en, cpu0_start, edac_en, full_if;
   logic [1:0]    link_en, dint_mode;
   logic [31:0]   status;

   rstseq_top #(.NUM_PLL(NP), .ACTIVE_MASK(ACT), .SYNC_STAGES(2), .GPIO_W(16)) u_dut (
      .clk(clk), .ext_rst_n(ext_rst_n), .pll_lock(pll_lock), .strap_lock_ignore(ign),
      .strap_dbg_en(dbg), .strap_break(brk), .strap_gpio(gp), .sys_rst_n(sys_rst_n),
      .pll_clk_en(pll_clk_en), .dbg_clk_en(dbg_clk_en), .eth_clk_en(eth_clk_en),
      .dbg_link_en(link_en), .dint_mode(dint_mode), .wdog_en(wdog_en), .cpu0_start(cpu0_start),
      .bootmem_edac_en(edac_en), .bootmem_full_if(full_if), .boot_status(status));

   // behavioural reference
   bit          m_e1, m_e2, m_rel, m_dbg, m_brk, m_ign, ok;
   bit [NP-1:0] m_l1, m_l2;
   bit [15:0]   m_gp;

   always @(posedge clk or negedge ext_rst_n) begin
      if (!ext_rst_n) begin
         m_e1 = 0; m_e2 = 0; m_l1 = '0; m_l2 = '0; m_rel = 0;
         m_gp = '0; m_dbg = 0; m_brk = 0; m_ign = 0;
      end else begin
         ok = m_e2 && (ign || ((m_l2 | ~ACT) == '1));
         if (ok && !m_rel) begin
            m_rel = 1; m_gp = gp; m_dbg = dbg; m_brk = brk; m_ign = ign;
         end
         m_e2 = m_e1; m_e1 = 1; m_l2 = m_l1; m_l1 = pll_lock;
      end
   end

   int compared = 0, mismatched = 0, cycles = 0;
   bit done = 0;

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      compared++;
      if (act !== exp) begin
         mismatched++;
         $display("FAIL %s actual=%h expected=%h at cycle %0d", tag, act, exp, cycles);
      end
   endtask

   always @(negedge clk) begin
      cycles++;
      if (!done) begin
         chk("R1 sys_rst_n", 32'(sys_rst_n), 32'(m_rel));
         chk("R2 R3 pll_clk_en", 32'(pll_clk_en), 32'(m_l2 | {NP{ign}}));
         chk("R4 boot_status", status, {m_rel, 12'b0, m_ign, m_brk, m_dbg, m_gp});
         chk("R5 dbg/eth clk", {30'b0, dbg_clk_en, eth_clk_en}, {30'b0, m_dbg, m_dbg});
         chk("R6 dbg_link_en", 32'(link_en),
             {30'b0, m_dbg && (m_gp[7:4] != 4'hF), m_dbg && (m_gp[3:0] != 4'hF)});
         chk("R7 dint_mode", 32'(dint_mode), 32'(m_gp[7:6]));
         chk("R8 wdog/cpu0", {30'b0, wdog_en, cpu0_start}, {30'b0, !m_dbg && m_brk, m_rel && !m_brk});
         chk("R9 bootmem", {30'b0, edac_en, full_if}, {30'b0, m_gp[14], !m_gp[15]});
      end
      if (cycles > 20000 && !done) begin
         mismatched++;
         compared++;
         $display("FAIL watchdog expired");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
         $finish;
      end
   end

   task automatic step(int n);
      for (int k = 0; k < n; k++) begin
         @(negedge clk);
         #1;
      end
   endtask

   // one boot: hold reset, set straps, release, apply locks, then disturb straps (R4)
   task automatic boot(logic [15:0] g, logic d, logic b, logic ig, logic [NP-1:0] lk, int lock_delay);
      step(1);
      ext_rst_n = 0; pll_lock = '0;
      gp = g; dbg = d; brk = b; ign = ig;
      step(3);
      ext_rst_n = 1;
      step(lock_delay);
      pll_lock = lk;
      step(8);
      gp = ~g; dbg = ~d; brk = ~b;
      step(4);
      pll_lock = '0;
      step(3);
   endtask

   initial begin
      step(4);
      boot(16'h1234, 1, 0, 0, 3'b011, 2);   // R1, R10: PLL2 never locks
      boot(16'h000F, 1, 0, 0, 3'b111, 0);   // R6 link0 off, locks with reset removal
      boot(16'h00F0, 1, 1, 0, 3'b011, 3);   // R6 link1 off, R7 mode 11, R8 debug halt
      boot(16'h4040, 0, 1, 0, 3'b011, 1);   // R5 debug off, R8 watchdog, R9 edac
      boot(16'h8080, 0, 0, 1, 3'b000, 2);   // R3 override with no lock, R9 alt pins
      boot(16'h0010, 1, 0, 0, 3'b001, 2);   // R10 negative: PLL1 missing, no release
      // strap bus stepping every cycle across the release edge (R4)
      step(1);
      ext_rst_n = 0; pll_lock = 3'b011; ign = 0; dbg = 1; brk = 0;
      step(3);
      ext_rst_n = 1;
      for (int k = 0; k < 12; k++) begin
         gp = 16'(k * 16'h1111 + 16'h0041);
         step(1);
      end
      step(4);
      done = 1;
      step(1);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end
endmodule